// File: doc/BRIEF.md
# Predicated Subvector Group Adder

This block adds two packed operand buffers element by element and writes the sums into a destination buffer that it holds itself. The work is arranged in groups: a request names a group count `vl` and a group size of one to four scalars, and every group is handled as one unit. The scalars are 8, 16 or 32 bits wide, and sums wrap modulo that width. Because group sizes need not be powers of two, element offsets are computed with a general multiply and not with shifts.

A per-group predicate mask can gate the operation. Bit i of the mask enables group i, and the sense of the mask can be inverted. A group that is disabled leaves every destination byte it covers untouched. Operation without a predicate may cover more groups than the mask has bits. A predicated request that covers more groups than the mask has bits is refused. So is a request with an unsupported width or a group count above the buffer capacity. A refused request raises an error flag together with `done` and writes nothing.

A request is accepted on a `start` pulse while the block is idle. The block then processes one group on each clock and pulses `done` when it finishes. The operand buffers must be held stable while `busy` is high. The destination buffer is cleared by reset and keeps its contents from one request to the next.

Top module: `sv_grp_adder`

## Requirements
- R1: For every enabled group i and every lane j below the group size s, the destination element at index i*s+j becomes the sum of the operand elements at that same index. Element e occupies bytes e*w to e*w+w-1 of each buffer, in little-endian order, where w is the element size in bytes.
- R2: The group size is given as `subvl_m1` + 1, so codes 0 to 3 select sizes 1 to 4. Sizes 3 and 1 give strides of 3 and 1 elements between groups.
- R3: `wsel` selects the element width: 0 is 8 bits, 1 is 16 bits and 2 is 32 bits. Sums wrap modulo the width, and the carry out of the top byte of an element never reaches the next element.
- R4: With `pred_en` high, group i is enabled when bit i of `pred_mask` is 1, or when it is 0 if `pred_inv` is high. With `pred_en` low, every group is enabled and `pred_inv` has no effect.
- R5: The destination bytes of disabled groups, of lanes at or above the group size and of elements beyond the last group keep their previous values.
- R6: If the clock edge that accepts `start` is counted as edge 0, an accepted request processes one group on each following edge, and `done` is high for one cycle after edge `vl`. A request with `vl` = 0 gives `done` after edge 0 and writes nothing.
- R7: A request is refused if `pred_en` is high and `vl` is greater than MASK_W, if `vl` is greater than MAX_VL, or if `wsel` is 3. A refused request makes `done` and `err` high together for one cycle after edge 0 and writes no destination byte.
- R8: A `start` that arrives while `busy` is high is ignored. It does not change the running request and does not cause another `done`.
- R9: After reset, `busy`, `done` and `err` are low and every destination byte is zero.
- R10: Without a predicate, `vl` may be any value up to MAX_VL, including values above MASK_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, accepted while idle |
| vl | input | VLW | Number of groups |
| subvl_m1 | input | 2 | Group size minus one |
| wsel | input | 2 | Element width code |
| pred_en | input | 1 | Use the predicate mask |
| pred_inv | input | 1 | Invert the sense of the predicate |
| pred_mask | input | MASK_W | One enable bit per group |
| a_buf | input | NBYTES*8 | First operand buffer, bytes packed little-endian |
| b_buf | input | NBYTES*8 | Second operand buffer |
| busy | output | 1 | A request is running |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Request refused (only with done) |
| dst_buf | output | NBYTES*8 | Destination buffer contents |

## Verification
Internal faults show up as wrong bytes in `dst_buf` or as a `done` pulse that arrives too early or too late. A wrong group counter or stride writes sums at shifted offsets. A wrong predicate index changes whole groups at once. A wrong width mask lets a carry cross into a neighbouring element. All of these can be seen in the full buffer comparison made right after `done`, and a latency fault can be seen at the `done` edge. Each request runs on top of the destination contents left by the one before it, so a stray write to bytes that should not change is caught at the next comparison.

// File: rtl/svadd_pkg.sv
package svadd_pkg;

   // lanes per group at most, bytes per lane at most
   localparam int unsigned LANES      = 4;
   localparam int unsigned LANE_BYTES = 4;
   localparam int unsigned LANE_BITS  = LANE_BYTES * 8;

   typedef enum logic [1:0] {
      EW_8   = 2'd0,
      EW_16  = 2'd1,
      EW_32  = 2'd2,
      EW_RSV = 2'd3
   } ew_e;

   function automatic logic [2:0] ew_nbytes(input ew_e ew);
      case (ew)
         EW_8:    return 3'd1;
         EW_16:   return 3'd2;
         default: return 3'd4;
      endcase
   endfunction

endpackage

// File: rtl/svadd_seq.sv
module svadd_seq
   import svadd_pkg::*;
#(
   parameter int unsigned MAX_VL = 10,
   parameter int unsigned MASK_W = 8,
   parameter int unsigned VLW    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [VLW-1:0]    vl,
   input  logic [1:0]        subvl_m1,
   input  logic [1:0]        wsel,
   input  logic              pred_en,
   input  logic              pred_inv,
   input  logic [MASK_W-1:0] pred_mask,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic [VLW-1:0]    grp,
   output logic              grp_en,
   output logic [2:0]        subvl_q,
   output ew_e               ew_q
);

   generate
      if (MAX_VL < 1) begin : g_chk_vl
         $error("svadd_seq: MAX_VL must be at least 1");
      end
      if (MASK_W < 1) begin : g_chk_mask
         $error("svadd_seq: MASK_W must be at least 1");
      end
      if ((1 << VLW) <= MAX_VL) begin : g_chk_vlw
         $error("svadd_seq: VLW too narrow for MAX_VL");
      end
   endgenerate

   logic [VLW-1:0]    vl_q;
   logic              pen_q;
   logic              pinv_q;
   logic [MASK_W-1:0] mask_q;
   logic              req_bad;
   logic              last_grp;
   logic [MASK_W-1:0] grp_sel;
   logic              mask_bit;

   always_comb begin
      req_bad = (int'(vl) > int'(MAX_VL))
             || (wsel == EW_RSV)
             || (pred_en && (int'(vl) > int'(MASK_W)));
   end

   assign last_grp = (grp == (vl_q - VLW'(1)));

   // a one-hot select beyond the mask width yields zero
   assign grp_sel  = MASK_W'(1) << grp;
   assign mask_bit = |(grp_sel & mask_q);
   assign grp_en   = !pen_q || (mask_bit ^ pinv_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         done    <= 1'b0;
         err     <= 1'b0;
         grp     <= '0;
         vl_q    <= '0;
         pen_q   <= 1'b0;
         pinv_q  <= 1'b0;
         mask_q  <= '0;
         subvl_q <= 3'd1;
         ew_q    <= EW_8;
      end else begin
         done <= 1'b0;
         err  <= 1'b0;
         if (busy) begin
            if (last_grp) begin
               busy <= 1'b0;
               done <= 1'b0 | 1'b1;
               grp  <= '0;
            end else begin
               grp <= grp + VLW'(1);
            end
         end else if (start) begin
            vl_q    <= vl;
            pen_q   <= pred_en;
            pinv_q  <= pred_inv;
            mask_q  <= pred_mask;
            subvl_q <= {1'b0, subvl_m1} + 3'd1;
            ew_q    <= ew_e'(wsel);
            grp     <= '0;
            if (req_bad) begin
               done <= 1'b1;
               err  <= 1'b1;
            end else if (vl == '0) begin
               done <= 1'b1;
            end else begin
               busy <= 1'b1;
            end
         end
      end
   end

   // R7: the error flag only ever comes with completion
   p_err_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> done);

   // R6: the group index stays inside the requested count
   p_grp_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (grp < vl_q));

   // R6: the final group is followed by completion and idle
   p_done_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && last_grp) |=> (done && !busy));

   // R8: the request in flight is not replaced
   p_cfg_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(vl_q) && $stable(mask_q) && $stable(pen_q)));

endmodule

// File: rtl/svadd_lane.sv
module svadd_lane
   import svadd_pkg::*;
#(
   parameter int unsigned NBYTES = 160,
   parameter int unsigned OFFW   = 9
) (
   input  logic [NBYTES*8-1:0]  a_flat,
   input  logic [NBYTES*8-1:0]  b_flat,
   input  logic [OFFW-1:0]      off,
   input  logic [2:0]           nbytes,
   output logic [LANE_BITS-1:0] sum
);

   logic [LANE_BITS-1:0] opa;
   logic [LANE_BITS-1:0] opb;

   // gather the bytes of one element, zero above the element width
   always_comb begin
      opa = '0;
      opb = '0;
      for (int k = 0; k < int'(LANE_BYTES); k++) begin
         if ((k < int'(nbytes)) && ((int'(off) + k) < int'(NBYTES))) begin
            opa[k*8 +: 8] = a_flat[(int'(off) + k)*8 +: 8];
            opb[k*8 +: 8] = b_flat[(int'(off) + k)*8 +: 8];
         end
      end
   end

   // full-width add; only the low nbytes are ever stored, which wraps
   assign sum = opa + opb;

endmodule

// File: rtl/svadd_dst.sv
module svadd_dst
   import svadd_pkg::*;
#(
   parameter int unsigned NBYTES = 160,
   parameter int unsigned OFFW   = 9
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [LANES-1:0]           wen,
   input  logic [LANES*OFFW-1:0]      off_flat,
   input  logic [LANES*LANE_BITS-1:0] sum_flat,
   input  logic [2:0]                 nbytes,
   output logic [NBYTES*8-1:0]        dst_flat
);

   logic [7:0] mem [NBYTES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int p = 0; p < int'(NBYTES); p++) begin
            mem[p] <= '0;
         end
      end else begin
         for (int j = 0; j < int'(LANES); j++) begin
            for (int k = 0; k < int'(LANE_BYTES); k++) begin
               if (wen[j] && (k < int'(nbytes))
                   && ((int'(off_flat[j*OFFW +: OFFW]) + k) < int'(NBYTES))) begin
                  mem[int'(off_flat[j*OFFW +: OFFW]) + k]
                     <= sum_flat[j*LANE_BITS + k*8 +: 8];
               end
            end
         end
      end
   end

   always_comb begin
      for (int p = 0; p < int'(NBYTES); p++) begin
         dst_flat[p*8 +: 8] = mem[p];
      end
   end

   generate
      for (genvar j = 0; j < int'(LANES); j++) begin : g_fit
         // R3: a written element lies wholly inside the buffer
         p_wr_fits_r3: assert property (@(posedge clk) disable iff (!rst_n)
            wen[j] |-> ((int'(off_flat[j*OFFW +: OFFW]) + int'(nbytes)) <= int'(NBYTES)));
      end
   endgenerate

endmodule

// File: rtl/sv_grp_adder.sv
module sv_grp_adder
   import svadd_pkg::*;
#(
   parameter int unsigned MAX_VL = 10,
   parameter int unsigned MASK_W = 8,
   localparam int unsigned NBYTES = MAX_VL * LANES * LANE_BYTES,
   localparam int unsigned BUF_W  = NBYTES * 8,
   localparam int unsigned VLW    = $clog2(MAX_VL + 1),
   localparam int unsigned OFFW   = $clog2(NBYTES) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [VLW-1:0]    vl,
   input  logic [1:0]        subvl_m1,
   input  logic [1:0]        wsel,
   input  logic              pred_en,
   input  logic              pred_inv,
   input  logic [MASK_W-1:0] pred_mask,
   input  logic [BUF_W-1:0]  a_buf,
   input  logic [BUF_W-1:0]  b_buf,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic [BUF_W-1:0]  dst_buf
);

   logic [VLW-1:0]             grp;
   logic                       grp_en;
   logic [2:0]                 subvl_q;
   ew_e                        ew_q;
   logic [2:0]                 nb;
   logic [LANES-1:0]           wen;
   logic [LANES*OFFW-1:0]      off_flat;
   logic [LANES*LANE_BITS-1:0] sum_flat;

   svadd_seq #(
      .MAX_VL (MAX_VL),
      .MASK_W (MASK_W),
      .VLW    (VLW)
   ) seq_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .vl        (vl),
      .subvl_m1  (subvl_m1),
      .wsel      (wsel),
      .pred_en   (pred_en),
      .pred_inv  (pred_inv),
      .pred_mask (pred_mask),
      .busy      (busy),
      .done      (done),
      .err       (err),
      .grp       (grp),
      .grp_en    (grp_en),
      .subvl_q   (subvl_q),
      .ew_q      (ew_q)
   );

   assign nb = ew_nbytes(ew_q);

   generate
      for (genvar j = 0; j < int'(LANES); j++) begin : g_lane
         logic [OFFW-1:0] off_j;

         // element index grp*s+j, scaled by the element size
         assign off_j = OFFW'((int'(grp) * int'(subvl_q) + j) * int'(nb));
         assign off_flat[j*OFFW +: OFFW] = off_j;
         assign wen[j] = busy && grp_en && (j < int'(subvl_q));

         svadd_lane #(
            .NBYTES (NBYTES),
            .OFFW   (OFFW)
         ) lane_i (
            .a_flat (a_buf),
            .b_flat (b_buf),
            .off    (off_j),
            .nbytes (nb),
            .sum    (sum_flat[j*LANE_BITS +: LANE_BITS])
         );
      end
   endgenerate

   svadd_dst #(
      .NBYTES (NBYTES),
      .OFFW   (OFFW)
   ) dst_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wen      (wen),
      .off_flat (off_flat),
      .sum_flat (sum_flat),
      .nbytes   (nb),
      .dst_flat (dst_buf)
   );

   // R5: nothing changes the destination while idle
   p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> $stable(dst_buf));

   // R5: a disabled group leaves the destination as it was
   p_skip_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !grp_en) |=> $stable(dst_buf));

   // R6: done is never raised while groups remain to be processed
   p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

endmodule

// File: tb/sv_grp_adder_tb_top.sv
`timescale 1ns/1ps
module sv_grp_adder_tb_top;

   localparam int MAX_VL = 10;
   localparam int MASK_W = 8;
   localparam int NB     = MAX_VL * 16;
   localparam int VLW    = $clog2(MAX_VL + 1);
   localparam int CLK_HALF = 10;

   typedef struct packed {
      logic [3:0] vl;
      logic [1:0] sm1;
      logic [1:0] ws;
      logic       pe;
      logic       pi;
      logic [7:0] mask;
      logic [7:0] seed;
      logic       xerr;
      logic [3:0] xlat;
   } row_t;

   localparam int NROWS = 10;
   localparam row_t TBL [NROWS] = '{
      '{4'd5,  2'd2, 2'd1, 1'b1, 1'b1, 8'h05, 8'd1, 1'b0, 4'd5},  // R2 s=3, R3 16b, R4 inverted
      '{4'd4,  2'd3, 2'd0, 1'b0, 1'b1, 8'h00, 8'd2, 1'b0, 4'd4},  // R4 inv ignored, 8b, s=4
      '{4'd6,  2'd0, 2'd2, 1'b1, 1'b0, 8'h2A, 8'd3, 1'b0, 4'd6},  // R2 s=1, 32b
      '{4'd3,  2'd1, 2'd2, 1'b1, 1'b0, 8'h07, 8'd4, 1'b0, 4'd3},  // s=2, 32b
      '{4'd8,  2'd2, 2'd0, 1'b1, 1'b0, 8'hA5, 8'd5, 1'b0, 4'd8},  // vl = mask width
      '{4'd10, 2'd3, 2'd2, 1'b0, 1'b0, 8'h00, 8'd6, 1'b0, 4'd10}, // R10 full buffer
      '{4'd9,  2'd0, 2'd1, 1'b1, 1'b0, 8'hFF, 8'd7, 1'b1, 4'd0},  // R7 pred over mask
      '{4'd0,  2'd3, 2'd1, 1'b0, 1'b0, 8'h00, 8'd8, 1'b0, 4'd0},  // R6 zero groups
      '{4'd11, 2'd0, 2'd0, 1'b0, 1'b0, 8'h00, 8'd9, 1'b1, 4'd0},  // R7 over capacity
      '{4'd2,  2'd1, 2'd3, 1'b0, 1'b0, 8'h00, 8'd10, 1'b1, 4'd0}  // R7 bad width
   };

   logic              clk;
   logic              rst_n;
   logic              start;
   logic [VLW-1:0]    vl;
   logic [1:0]        subvl_m1;
   logic [1:0]        wsel;
   logic              pred_en;
   logic              pred_inv;
   logic [MASK_W-1:0] pred_mask;
   logic [NB*8-1:0]   a_buf;
   logic [NB*8-1:0]   b_buf;
   logic              busy;
   logic              done;
   logic              err;
   logic [NB*8-1:0]   dst_buf;

   logic [7:0] ab [NB];
   logic [7:0] bb [NB];
   logic [7:0] ex [NB];

   int n_checks;
   int n_fail;
   int lat;

   sv_grp_adder #(.MAX_VL(MAX_VL), .MASK_W(MASK_W)) dut_i (
      .clk (clk), .rst_n (rst_n), .start (start), .vl (vl),
      .subvl_m1 (subvl_m1), .wsel (wsel), .pred_en (pred_en),
      .pred_inv (pred_inv), .pred_mask (pred_mask),
      .a_buf (a_buf), .b_buf (b_buf), .busy (busy), .done (done),
      .err (err), .dst_buf (dst_buf)
   );

   initial clk = 1'b0;
   always #(CLK_HALF) clk = ~clk;

   always_comb begin
      for (int p = 0; p < NB; p++) begin
         a_buf[p*8 +: 8] = ab[p];
         b_buf[p*8 +: 8] = bb[p];
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic fill(input int seed);
      for (int p = 0; p < NB; p++) begin
         ab[p] = 8'(p * 37 + seed * 11 + 5);
         bb[p] = 8'(p * 91 + seed * 3 + 192);
      end
   endtask

   // expected destination from R1-style formula with bytewise carry
   task automatic model(input int n, input int s, input int w,
                        input bit pe, input bit pi, input logic [7:0] mask);
      for (int i = 0; i < n; i++) begin
         bit en;
         en = !pe || (mask[i] != pi);
         if (en) begin
            for (int j = 0; j < s; j++) begin
               int o;
               int c;
               o = (i * s + j) * w;
               c = 0;
               for (int k = 0; k < w; k++) begin
                  int t;
                  t = int'(ab[o + k]) + int'(bb[o + k]) + c;
                  ex[o + k] = 8'(t);
                  c = t >> 8;
               end
            end
         end
      end
   endtask

   task automatic cmp_dst(input string tag);
      int bad_idx;
      bad_idx = -1;
      for (int p = 0; p < NB; p++) begin
         if (bad_idx < 0 && dst_buf[p*8 +: 8] !== ex[p]) bad_idx = p;
      end
      if (bad_idx < 0) check(1'b1, tag, 0, 0);
      else check(1'b0, {tag, " dst byte"}, int'(dst_buf[bad_idx*8 +: 8]), int'(ex[bad_idx]));
   endtask

   task automatic kick(input int n, input int sm1, input int ws,
                       input bit pe, input bit pi, input logic [7:0] mask);
      @(negedge clk);
      vl = VLW'(n); subvl_m1 = 2'(sm1); wsel = 2'(ws);
      pred_en = pe; pred_inv = pi; pred_mask = mask;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = 0;
      while (!done && lat < 40) begin
         @(negedge clk);
         lat++;
      end
   endtask

   function automatic int wbytes(input int ws);
      return (ws == 0) ? 1 : (ws == 1) ? 2 : 4;
   endfunction

   initial begin
      #(CLK_HALF * 2 * 150000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      n_checks = 0; n_fail = 0;
      rst_n = 1'b0; start = 1'b0; vl = '0; subvl_m1 = '0; wsel = '0;
      pred_en = 1'b0; pred_inv = 1'b0; pred_mask = '0;
      fill(0);
      for (int p = 0; p < NB; p++) ex[p] = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R9: reset state
      check(busy == 1'b0, "R9 busy", int'(busy), 0);
      check(done == 1'b0, "R9 done", int'(done), 0);
      check(err == 1'b0, "R9 err", int'(err), 0);
      cmp_dst("R9 cleared");

      // table walk: R1 R2 R3 R4 R5 R6 R7 R10
      for (int r = 0; r < NROWS; r++) begin
         row_t t;
         t = TBL[r];
         fill(int'(t.seed));
         kick(int'(t.vl), int'(t.sm1), int'(t.ws), t.pe, t.pi, t.mask);
         check(lat == int'(t.xlat), t.xerr ? "R7 latency" : "R6 latency", lat, int'(t.xlat));
         check(err == t.xerr, "R7 err flag", int'(err), int'(t.xerr));
         if (!t.xerr) model(int'(t.vl), int'(t.sm1) + 1, wbytes(int'(t.ws)), t.pe, t.pi, t.mask);
         cmp_dst(t.xerr ? "R7 no write" : "R1 R5 table result");
      end

      // R3: wrap at the element top, no carry into the neighbour
      for (int p = 0; p < NB; p++) begin
         ab[p] = 8'hFF;
         bb[p] = (p % 2 == 0) ? 8'h01 : 8'h00;
      end
      kick(2, 3, 1, 1'b0, 1'b0, 8'h00);
      model(2, 4, 2, 1'b0, 1'b0, 8'h00);
      check(lat == 2, "R6 latency wrap", lat, 2);
      cmp_dst("R3 wrap 16b");

      // R8: start while busy is ignored
      fill(21);
      @(negedge clk);
      vl = VLW'(4); subvl_m1 = 2'd1; wsel = 2'd0;
      pred_en = 1'b0; pred_inv = 1'b0; pred_mask = '0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      vl = VLW'(2); wsel = 2'd2; pred_en = 1'b1; pred_mask = 8'h00;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = 2;
      while (!done && lat < 40) begin
         @(negedge clk);
         lat++;
      end
      model(4, 2, 1, 1'b0, 1'b0, 8'h00);
      check(lat == 4, "R8 first request latency", lat, 4);
      cmp_dst("R8 first request result");
      begin
         int extra;
         extra = 0;
         for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            if (done) extra++;
         end
         check(extra == 0, "R8 no second done", extra, 0);
      end
      cmp_dst("R8 buffer after ignored start");

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule